// File: doc/BRIEF.md
# Prioritizing Timing Event Link Transmitter

This block drives a serial timing link that carries one 8-bit event code per frame, each code followed by an even-parity bit. It runs from a single link clock supplied from outside (in the target machine, 32 times the ring revolution frequency). Every link clock moves one bit onto the line. Frames follow one another with no gap. When nothing is waiting to go out, the link carries the null code 0x00.

Two sources feed the link. Hardware trigger lines cover the low code range and are grouped in banks of 16 lines. Each line is latched on its rising edge, so a single-cycle pulse is never lost. A software request port covers the remaining codes and queues them in a small FIFO. At each frame boundary the block chooses what to send. Pending hardware codes always go first, lowest code first. Software codes go out in the order they were written, but only while the time-critical window input is low.

Top module: `evt_link_tx`

## Requirements
- R1: The line carries back-to-back 9-bit frames. `sync_o` is high exactly on the first bit of each frame. A frame is the 8 code bits, most significant first, then the parity bit.
- R2: The parity bit equals the XOR of the 8 code bits, so every frame holds an even number of ones.
- R3: A frame that starts with no eligible request carries code 0x00.
- R4: A rising edge on `hw_req_i[k]`, for k from 1 to 63, makes code k go out exactly once. This holds even if the line is high for a single cycle, and even if it stays high for many frames. Line 0 has no effect.
- R5: When several hardware codes are pending at a frame boundary, the lowest code is sent first.
- R6: When hardware and software codes are both pending at a frame boundary, a hardware code is sent.
- R7: A software write with a code below 64 is discarded.
- R8: While `crit_i` is high at a frame boundary, no software code starts. Queued software codes go out after the window closes, in write order.
- R9: The software FIFO holds 16 codes and keeps write order. `sw_full_o` is high while it holds 16.
- R10: A software write while `sw_full_o` is high is dropped and sets `sw_ovf_o`. `sw_ovf_o` stays high until reset.
- R11: During reset `ser_o`, `sw_full_o` and `sw_ovf_o` are low. The first frame after reset is a null frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | 64 | Hardware trigger lines; bit k requests code k (bit 0 unused) |
| crit_i | input | 1 | Time-critical window; holds back software codes |
| sw_valid_i | input | 1 | Software write strobe |
| sw_code_i | input | 8 | Software event code (64 to 255) |
| sw_full_o | output | 1 | Software FIFO is full |
| sw_ovf_o | output | 1 | Sticky flag for a dropped software write |
| ser_o | output | 1 | Serial link data |
| sync_o | output | 1 | High on the first bit of each frame |

## Verification
The bench builds the block with its default parameters: four banks of 16 lines and a 16-entry software FIFO. With these values the full hardware code range 1 to 63 can be reached, including codes in different banks that are raised in the same cycle. The FIFO can be filled to its limit and pushed one write past it, so the full flag, the overflow flag and the critical-window hold can all be seen while the queue is at its limit. A scoreboard decodes every frame from the line and compares the decoded order with the order that the priority and window rules predict.

// File: rtl/evt_link_pkg.sv
package evt_link_pkg;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned FRAME_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] NULL_CODE = '0;

  typedef logic [CODE_W-1:0] code_t;

  function automatic logic [FRAME_W-1:0] make_frame(code_t c);
    return {c, ^c};
  endfunction
endpackage

// File: rtl/evt_hw_arb.sv
module evt_hw_arb
  import evt_link_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_SIZE = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_BANKS*BANK_SIZE-1:0] req_i,
  input  logic                           take_i,
  output logic                           any_o,
  output code_t                          code_o
);
  localparam int unsigned N     = NUM_BANKS * BANK_SIZE;
  localparam int unsigned IDX_W = $clog2(BANK_SIZE);

  logic [N-1:0] prev_q, pend_q, rise, clr;
  logic [NUM_BANKS-1:0] bank_any;
  logic [IDX_W-1:0]     bank_idx [NUM_BANKS];

  // line 0 maps to the null code and never latches
  assign rise = req_i & ~prev_q & ~N'(1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_SIZE-1:0] slice;
    assign slice = pend_q[b*BANK_SIZE +: BANK_SIZE];
    always_comb begin
      bank_idx[b] = '0;
      for (int i = BANK_SIZE - 1; i >= 0; i--)
        if (slice[i]) bank_idx[b] = IDX_W'(i);
    end
    assign bank_any[b] = |slice;
  end

  always_comb begin
    code_o = NULL_CODE;
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (bank_any[b]) code_o = CODE_W'(b * BANK_SIZE) + CODE_W'(bank_idx[b]);
  end

  assign any_o = |bank_any;

  always_comb begin
    clr = '0;
    if (take_i && any_o) clr[code_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= req_i;
      pend_q <= (pend_q & ~clr) | rise;
    end
  end
endmodule

// File: rtl/evt_sw_fifo.sv
module evt_sw_fifo
  import evt_link_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned MIN_CODE = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  code_t                      wr_code_i,
  input  logic                       pop_i,
  output code_t                      rd_code_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic                       ovf_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  code_t             mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_range, push, pop;

  assign in_range  = wr_code_i >= CODE_W'(MIN_CODE);
  assign full_o    = cnt_q == CNT_W'(DEPTH);
  assign empty_o   = cnt_q == '0;
  assign push      = wr_i && in_range && !full_o;
  assign pop       = pop_i && !empty_o;
  assign rd_code_o = mem[rd_ptr_q];
  assign cnt_o     = cnt_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_ptr_q] <= wr_code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      if (wr_i && in_range && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_serializer.sv
module evt_serializer
  import evt_link_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t next_code_i,
  output logic  load_o,
  output logic  ser_o,
  output logic  sync_o
);
  localparam int unsigned BIT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame_q;
  logic [BIT_W-1:0]   bit_q;

  assign load_o = bit_q == BIT_W'(FRAME_W - 1);
  assign ser_o  = frame_q[FRAME_W-1];
  assign sync_o = bit_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= make_frame(NULL_CODE);
      bit_q   <= '0;
    end else if (load_o) begin
      frame_q <= make_frame(next_code_i);
      bit_q   <= '0;
    end else begin
      frame_q <= frame_q << 1;
      bit_q   <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/evt_link_tx.sv
module evt_link_tx
  import evt_link_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_SIZE = 16,
  parameter int unsigned SW_DEPTH  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_BANKS*BANK_SIZE-1:0] hw_req_i,
  input  logic                           crit_i,
  input  logic                           sw_valid_i,
  input  logic [7:0]                     sw_code_i,
  output logic                           sw_full_o,
  output logic                           sw_ovf_o,
  output logic                           ser_o,
  output logic                           sync_o
);
  localparam int unsigned HW_CODES = NUM_BANKS * BANK_SIZE;
  localparam int unsigned CNT_W    = $clog2(SW_DEPTH + 1);

  logic             load_w, hw_any_w, sw_empty_w, take_hw, take_sw;
  code_t            hw_code_w, sw_code_w, next_code;
  logic [CNT_W-1:0] sw_cnt_w;

  evt_hw_arb #(.NUM_BANKS(NUM_BANKS), .BANK_SIZE(BANK_SIZE)) u_hw (
    .clk_i, .rst_ni, .req_i(hw_req_i), .take_i(take_hw),
    .any_o(hw_any_w), .code_o(hw_code_w)
  );

  evt_sw_fifo #(.DEPTH(SW_DEPTH), .MIN_CODE(HW_CODES)) u_sw (
    .clk_i, .rst_ni, .wr_i(sw_valid_i), .wr_code_i(sw_code_i),
    .pop_i(take_sw), .rd_code_o(sw_code_w), .empty_o(sw_empty_w),
    .full_o(sw_full_o), .ovf_o(sw_ovf_o), .cnt_o(sw_cnt_w)
  );

  // hardware wins; software only outside the critical window
  assign take_hw = load_w && hw_any_w;
  assign take_sw = load_w && !hw_any_w && !crit_i && !sw_empty_w;

  always_comb begin
    if (take_hw)      next_code = hw_code_w;
    else if (take_sw) next_code = sw_code_w;
    else              next_code = NULL_CODE;
  end

  evt_serializer u_ser (
    .clk_i, .rst_ni, .next_code_i(next_code),
    .load_o(load_w), .ser_o, .sync_o
  );
endmodule

// File: rtl/evt_link_tx_chk.sv
module evt_link_tx_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             crit_i,
  input logic             sw_valid_i,
  input logic             sw_full_o,
  input logic             sw_ovf_o,
  input logic             sync_o,
  input logic             load_i,
  input logic             hw_any_i,
  input logic [CNT_W-1:0] sw_cnt_i
);
  a_r1_sync_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  a_r6_hw_before_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && hw_any_i) |=> sw_cnt_i >= $past(sw_cnt_i));

  a_r8_crit_holds_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && crit_i) |=> sw_cnt_i >= $past(sw_cnt_i));

  a_r9_full_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_full_o |=> sw_cnt_i <= $past(sw_cnt_i));

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_ovf_o |=> sw_ovf_o);

  a_r10_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_ovf_o) |-> $past(sw_full_o && sw_valid_i));
endmodule

bind evt_link_tx evt_link_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .crit_i(crit_i), .sw_valid_i(sw_valid_i),
  .sw_full_o(sw_full_o), .sw_ovf_o(sw_ovf_o), .sync_o(sync_o),
  .load_i(load_w), .hw_any_i(hw_any_w), .sw_cnt_i(sw_cnt_w)
);

// File: tb/tb_evt_link_tx.sv
module tb_evt_link_tx;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] hw_req = '0;
  logic        crit = 1'b1;
  logic        sw_valid = 1'b0;
  logic [7:0]  sw_code = '0;
  logic        sw_full, sw_ovf, ser, sync;

  int n_chk = 0, n_fail = 0;
  int frames_seen = 0, null_frames = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_link_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .crit_i(crit),
    .sw_valid_i(sw_valid), .sw_code_i(sw_code), .sw_full_o(sw_full),
    .sw_ovf_o(sw_ovf), .ser_o(ser), .sync_o(sync)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sw_write(logic [7:0] c);
    @(negedge clk);
    sw_valid = 1'b1;
    sw_code  = c;
    @(negedge clk);
    sw_valid = 1'b0;
  endtask

  // monitor: rebuild frames from the line and score them
  initial begin
    bit         started = 1'b0;
    int         nbits = 0;
    logic [8:0] fr = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        started = 1'b0;
      end else if (sync) begin
        if (started) chk(nbits == 9, "R1 frame length", nbits, 9);
        started = 1'b1;
        nbits = 1;
        fr = {8'b0, ser};
      end else if (started) begin
        fr = {fr[7:0], ser};
        nbits++;
        if (nbits == 9) begin
          chk(fr[0] == ^fr[8:1], "R2 parity", fr[0], ^fr[8:1]);
          if (fr[8:1] == 8'h00) null_frames++;
          else begin
            frames_seen++;
            if (exp_q.size() == 0) chk(1'b0, "R4/R7/R8 unexpected code", fr[8:1], 0);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(fr[8:1] == e, "R5/R6/R9 code order", fr[8:1], e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seen;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(ser == 1'b0, "R11 ser in reset", ser, 0);
    chk(sw_full == 1'b0, "R11 full in reset", sw_full, 0);
    chk(sw_ovf == 1'b0, "R11 ovf in reset", sw_ovf, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(frames_seen == 0, "R11 R3 null after reset", frames_seen, 0);

    // R6 R5 R4 R7: software queued under the window, then hw burst
    sw_write(8'h80);
    sw_write(8'h81);
    sw_write(8'h10);   // R7 below range, discarded
    sw_write(8'h82);
    do @(negedge clk); while (!sync);
    hw_req[40] = 1'b1; hw_req[5] = 1'b1; hw_req[3] = 1'b1; hw_req[0] = 1'b1;
    crit = 1'b0;
    exp_q.push_back(8'd3);
    exp_q.push_back(8'd5);
    exp_q.push_back(8'd40);
    exp_q.push_back(8'h80);
    exp_q.push_back(8'h81);
    exp_q.push_back(8'h82);
    @(negedge clk);
    hw_req[40] = 1'b0; hw_req[3] = 1'b0; hw_req[0] = 1'b0;  // one-cycle pulses
    repeat (80) @(negedge clk);
    hw_req[5] = 1'b0;                                         // held line sends once
    while (exp_q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(frames_seen == 6, "R4 count after burst", frames_seen, 6);

    // R9 R10 R8: fill under the window, overflow, hold, then drain
    crit = 1'b1;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 16; i++) sw_write(8'hA0 + 8'(i));
    chk(sw_full == 1'b1, "R9 full at 16", sw_full, 1);
    chk(sw_ovf == 1'b0, "R10 no ovf yet", sw_ovf, 0);
    sw_write(8'hFF);
    chk(sw_ovf == 1'b1, "R10 ovf set", sw_ovf, 1);
    chk(sw_full == 1'b1, "R10 full kept", sw_full, 1);
    seen = frames_seen;
    repeat (100) @(negedge clk);
    chk(frames_seen == seen, "R8 window holds sw", frames_seen, seen);
    for (int i = 0; i < 16; i++) exp_q.push_back(8'hA0 + 8'(i));
    crit = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(sw_full == 1'b0, "R9 full clears", sw_full, 0);
    chk(sw_ovf == 1'b1, "R10 ovf sticky", sw_ovf, 1);
    chk(frames_seen == seen + 16, "R10 dropped write absent", frames_seen, seen + 16);

    // R8 window closing mid-queue with a hw code arriving
    crit = 1'b1;
    sw_write(8'hC1);
    sw_write(8'hC2);
    do @(negedge clk); while (!sync);
    hw_req[62] = 1'b1;
    exp_q.push_back(8'd62);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R8 hw passes window", exp_q.size(), 0);
    hw_req[62] = 1'b0;
    exp_q.push_back(8'hC1);
    exp_q.push_back(8'hC2);
    crit = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);

    chk(null_frames > 0, "R3 idle null frames", null_frames, 1);
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule